// File: doc/BRIEF.md
# Single-Precision Truncating Floating-Point Multiplier

This block takes two 32-bit binary floating-point words and returns their product in the same format. Each word has a sign bit at bit 31, an 8-bit exponent field in bits 30:23 with an offset of 127, and a 23-bit fraction in bits 22:0. The result sign is the exclusive OR of the operand signs. The exponent fields are summed and the offset is taken out once. The two 24-bit significands, each with its leading one restored, are multiplied into a 48-bit product. That product is normalised, and every bit below the kept fraction is thrown away. The block does no rounding.

A caller presents both operands with `in_valid` high for one clock. The packed result and its two range flags are captured on that edge and held until the next accepted operation. `done` is high for the cycle that follows the capture. When the exponent leaves the representable range, the word saturates to a signed infinity or collapses to a signed zero, and the matching flag is raised. NaN handling and other rounding modes are not provided.

Top module: `fp32_mul_trunc`

## Requirements
- R1: The result sign bit (bit 31) equals the XOR of the sign bits of `op_a` and `op_b` in every case, including zero, overflow and underflow results.
- R2: For non-zero operands whose result is in range, the result exponent field equals `ea + eb - 127 + n`. Here ea and eb are the operand exponent fields, and n is 1 when the significand product is 2.0 or more and 0 otherwise.
- R3: The significand product P is formed from the 24-bit values {1, fraction}. If P bit 47 is set, the result fraction is P[46:24]. Otherwise it is P[45:23]. All lower bits are discarded, so a dropped remainder of exactly one half or more never increments the fraction.
- R4: When the biased result exponent from R2 is above 254, the result is sign, exponent field 0xFF and fraction 0, and `ovf` is 1. A carry from normalisation alone can cause this.
- R5: When the biased result exponent from R2 is below 1, the result is sign followed by 31 zero bits, and `unf` is 1. A normalisation carry that lifts the exponent to 1 prevents underflow.
- R6: An operand with exponent field 0 and fraction 0 is a zero. If either operand is a zero, the result is the XOR sign followed by 31 zero bits, with `ovf` and `unf` both 0, whatever the other operand holds.
- R7: `result`, `ovf` and `unf` are loaded on the rising edge at which `in_valid` is 1. `done` is 1 in the clock cycle after that edge. Consecutive valid cycles give consecutive results and a `done` that stays high.
- R8: When `in_valid` is 0 at a rising edge, `result`, `ovf` and `unf` keep their values and `done` is 0 in the following cycle.
- R9: While `rst_n` is 0, `result`, `ovf`, `unf` and `done` are all 0.
- R10: A non-zero operand with exponent field 0 still gets a leading one on its significand and uses 0 as its exponent field in R2. For example, 0x00000001 times 0x7F000000 gives 0x3F800001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands present; accepted on this edge |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | output | 32 | Registered product word |
| ovf | output | 1 | Registered overflow flag for `result` |
| unf | output | 1 | Registered underflow flag for `result` |
| done | output | 1 | One-cycle pulse after each accepted operation |

## Verification
Normalisation and range detection can act on the same operation. The carry from a product of 2.0 or more raises the exponent by one in the same cycle that the range is judged. The bench drives operand pairs whose exponent sum sits exactly on a boundary. A sum of 254 with significands 1.5 and 1.5 must turn into an overflow. A sum of 0 with the same significands must escape underflow and give a normal number. The same sums with significands of 1.0 must stay on the other side of each boundary. Each outcome is compared against a behavioural reference computed with wide integers and against constants worked out by hand.

// File: rtl/fp32_mul_pkg.sv
// Package: shared defaults and the result class for the truncating multiplier.
// Assumes binary32 layout by default; widths are overridable at the top.
package fp32_mul_pkg;

    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;

    // Which packing rule applies to an operation
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_OVF    = 2'd2,
        CLS_UNF    = 2'd3
    } res_class_e;

endpackage

// File: rtl/fpm_unpack.sv
// Module: fpm_unpack
// Splits one floating-point word into sign, exponent field and significand
// with the leading one always restored. Flags the word as zero when both
// exponent and fraction are zero. Assumes sign is the top bit, exponent next.
module fpm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [W-1:0]     word,
    output logic             sign,
    output logic [EXP_W-1:0] exp_f,
    output logic [SIG_W-1:0] sig,
    output logic             is_zero
);

    logic [FRAC_W-1:0] frac;

    // Field split
    always_comb begin
        sign  = word[W-1];
        exp_f = word[W-2:FRAC_W];
        frac  = word[FRAC_W-1:0];
    end

    // Significand with hidden one, and zero detection
    always_comb begin
        sig     = {1'b1, frac};
        is_zero = (exp_f == '0) && (frac == '0);
    end

endmodule

// File: rtl/fpm_sig_mul.sv
// Module: fpm_sig_mul
// Multiplies two significands (each in [1,2)) and normalises the product.
// norm is set when the product reaches 2.0; the kept fraction is then taken
// one position higher. Everything below the kept fraction is truncated.
module fpm_sig_mul #(
    parameter int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic              norm,
    output logic [FRAC_W-1:0] frac
);

    logic [PROD_W-1:0] prod;

    // Full-width significand product
    always_comb prod = sig_a * sig_b;

    // Normalise and truncate to the fraction width
    always_comb begin
        norm = prod[PROD_W-1];
        if (norm)
            frac = FRAC_W'(prod >> SIG_W);
        else
            frac = FRAC_W'(prod >> (SIG_W - 1));
    end

endmodule

// File: rtl/fpm_exp_path.sv
// Module: fpm_exp_path
// Adds the two exponent fields, removes one offset, and adds the
// normalisation carry. This is done two bits wider than the field and signed,
// so the range can be judged before packing. Assumes offset 2^(EXP_W-1)-1.
module fpm_exp_path #(
    parameter int EXP_W = 8,
    localparam int XW   = EXP_W + 2,
    localparam int BIAS = (1 << (EXP_W - 1)) - 1,
    localparam int EMAX = (1 << EXP_W) - 2
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic             norm,
    output logic [EXP_W-1:0] exp_out,
    output logic             too_big,
    output logic             too_small
);

    logic signed [XW-1:0] sum_raw;
    logic signed [XW-1:0] sum_adj;

    // Field sum, then offset removal with a second adder
    always_comb begin
        sum_raw = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b});
        sum_adj = sum_raw - $signed(XW'(BIAS)) + $signed({{(XW-1){1'b0}}, norm});
    end

    // Range judgement and field extraction
    always_comb begin
        too_big   = sum_adj > $signed(XW'(EMAX));
        too_small = sum_adj < $signed(XW'(1));
        exp_out   = EXP_W'(sum_adj);
    end

endmodule

// File: rtl/fp32_mul_trunc.sv
// Module: fp32_mul_trunc (top)
// Truncating floating-point multiplier with one register stage. The sign,
// exponent and significand paths run in parallel. A class decision picks the
// packing rule (zero, overflow, underflow or normal), and the packed word and
// flags are captured on a valid edge. done follows one cycle later.
// Assumes a synchronous active-low reset and no NaN handling.
module fp32_mul_trunc
    import fp32_mul_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         unf,
    output logic         done
);

    logic [W-1:0]     ops   [2];
    logic [1:0]       sgn;
    logic [EXP_W-1:0] exps  [2];
    logic [SIG_W-1:0] sigs  [2];
    logic [1:0]       zer;

    logic              norm;
    logic [FRAC_W-1:0] frac_m;
    logic [EXP_W-1:0]  exp_m;
    logic              too_big;
    logic              too_small;
    logic              sign_r;
    res_class_e        cls;
    logic [W-1:0]      packed_w;

    logic [W-1:0] result_q;
    logic         ovf_q;
    logic         unf_q;
    logic         done_q;

    // Operand array for the repeated unpack stage
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word    (ops[g]),
            .sign    (sgn[g]),
            .exp_f   (exps[g]),
            .sig     (sigs[g]),
            .is_zero (zer[g])
        );
    end

    fpm_sig_mul #(.FRAC_W(FRAC_W)) u_sig (
        .sig_a (sigs[0]),
        .sig_b (sigs[1]),
        .norm  (norm),
        .frac  (frac_m)
    );

    fpm_exp_path #(.EXP_W(EXP_W)) u_exp (
        .exp_a     (exps[0]),
        .exp_b     (exps[1]),
        .norm      (norm),
        .exp_out   (exp_m),
        .too_big   (too_big),
        .too_small (too_small)
    );

    // Result class: zero operand wins, then overflow, then underflow
    always_comb begin
        sign_r = sgn[0] ^ sgn[1];
        if (|zer)
            cls = CLS_ZERO;
        else if (too_big)
            cls = CLS_OVF;
        else if (too_small)
            cls = CLS_UNF;
        else
            cls = CLS_NORMAL;
    end

    // Pack the word according to its class
    always_comb begin
        unique case (cls)
            CLS_OVF:    packed_w = {sign_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_NORMAL: packed_w = {sign_r, exp_m, frac_m};
            default:    packed_w = {sign_r, {(W-1){1'b0}}};
        endcase
    end

    // Output register: load on valid, pulse done one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= in_valid;
            if (in_valid) begin
                result_q <= packed_w;
                ovf_q    <= (cls == CLS_OVF);
                unf_q    <= (cls == CLS_UNF);
            end
        end
    end

    // Drive ports from the register stage
    always_comb begin
        result = result_q;
        ovf    = ovf_q;
        unf    = unf_q;
        done   = done_q;
    end

endmodule

// File: rtl/fpm_checker.sv
// Module: fpm_checker
// Temporal checks on the multiplier's ports, attached by bind below.
// Assumes the same widths as the bound top.
module fpm_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] result,
    input logic         ovf,
    input logic         unf,
    input logic         done
);

    // R7
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    // R8
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(ovf) && $stable(unf)));

    // R1
    sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result[W-1] == $past(op_a[W-1] ^ op_b[W-1])));

    // R4
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (result[W-2:FRAC_W] == {EXP_W{1'b1}} && result[FRAC_W-1:0] == '0));

    // R5
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (result[W-2:0] == '0));

    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    // R6
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((op_a[W-2:0] == '0) || (op_b[W-2:0] == '0)))
        |=> (result[W-2:0] == '0 && !ovf && !unf));

endmodule

bind fp32_mul_trunc fpm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .result   (result),
    .ovf      (ovf),
    .unf      (unf),
    .done     (done)
);

// File: tb/fp32_mul_trunc_test.sv
// Bench for fp32_mul_trunc. A behavioural reference built on wide integers
// gives the expected word and flags. done and the hold behaviour are
// compared at every falling edge.
module fp32_mul_trunc_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] result;
    logic        ovf;
    logic        unf;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    bit summary_done = 1'b0;

    logic [31:0] last_r;
    logic        last_o;
    logic        last_u;

    fp32_mul_trunc uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .result   (result),
        .ovf      (ovf),
        .unf      (unf),
        .done     (done)
    );

    always #2 clk = ~clk;

    // Behavioural reference product
    function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] r, output logic o,
                                    output logic u);
        logic   s;
        longint ma, mb, p, fr;
        int     ea, eb, e, n;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        o  = 1'b0;
        u  = 1'b0;
        if ((a[30:0] == 0) || (b[30:0] == 0)) begin
            r = {s, 31'd0};
            return;
        end
        ma = (longint'(1) << 23) + longint'(a[22:0]);
        mb = (longint'(1) << 23) + longint'(b[22:0]);
        p  = ma * mb;
        n  = (p >= (longint'(1) << 47)) ? 1 : 0;
        e  = ea + eb - 127 + n;
        fr = (n == 1) ? (p / (longint'(1) << 24)) : (p / (longint'(1) << 23));
        fr = fr % (longint'(1) << 23);
        if (e > 254) begin
            r = {s, 8'hFF, 23'd0};
            o = 1'b1;
        end else if (e < 1) begin
            r = {s, 31'd0};
            u = 1'b1;
        end else begin
            r = {s, e[7:0], fr[22:0]};
        end
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    // Present one operation at a falling edge; check at the next falling edge
    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] er, input logic eo, input logic eu,
                         input string req);
        in_valid = 1'b1;
        op_a     = a;
        op_b     = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", {req, " done"}, {31'd0, done}, 32'd1);
        check(req, "result", result, er);
        check(req, "flags", {30'd0, ovf, unf}, {30'd0, eo, eu});
        last_r = er;
        last_o = eo;
        last_u = eu;
    endtask

    task automatic issue_ref(input logic [31:0] a, input logic [31:0] b,
                             input string req);
        logic [31:0] r;
        logic        o, u;
        ref_mul(a, b, r, o, u);
        issue(a, b, r, o, u, req);
    endtask

    // Idle cycles with operands toggling: nothing may move (R8)
    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            op_a = 32'h40490FDB ^ 32'(i);
            op_b = 32'hC0000000 + 32'(i);
            @(negedge clk);
            check("R8", "idle done", {31'd0, done}, 32'd0);
            check("R8", "idle hold", result, last_r);
            check("R8", "idle flags", {30'd0, ovf, unf}, {30'd0, last_o, last_u});
        end
    endtask

    task automatic summary;
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] ra, rb;
        seed     = 32'h1234ABCD;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        op_a     = 32'h40000000;
        op_b     = 32'h40400000;
        repeat (3) @(negedge clk);
        // R9: reset holds everything at zero even with valid high
        check("R9", "reset result", result, 32'd0);
        check("R9", "reset flags", {30'd0, ovf, unf}, 32'd0);
        check("R9", "reset done", {31'd0, done}, 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        last_r = 32'd0; last_o = 1'b0; last_u = 1'b0;
        @(negedge clk);

        // R2: plain products
        issue(32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0, "R2");
        // R1: negative operand
        issue(32'hC0000000, 32'h40400000, 32'hC0C00000, 1'b0, 1'b0, "R1");
        // R3: product at or above 2.0 normalises
        issue(32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, "R3");
        // R3: half-ulp remainder is dropped (not normalised path)
        issue(32'h3FC00000, 32'h3F800001, 32'h3FC00001, 1'b0, 1'b0, "R3");
        // R3: three-quarter-ulp remainder dropped (normalised path)
        issue(32'h3FC00001, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, "R3");
        idle(2);

        // R6: zero operands
        issue(32'h00000000, 32'h40400000, 32'h00000000, 1'b0, 1'b0, "R6");
        issue(32'h80000000, 32'h40400000, 32'h80000000, 1'b0, 1'b0, "R6");
        issue(32'h7F000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0, "R6");
        // R4: overflow, both signs
        issue(32'h7F000000, 32'h7F000000, 32'h7F800000, 1'b1, 1'b0, "R4");
        issue(32'hFF000000, 32'h7F000000, 32'hFF800000, 1'b1, 1'b0, "R4");
        // R4: overflow caused by normalisation carry only
        issue(32'h7F400000, 32'h3FC00000, 32'h7F800000, 1'b1, 1'b0, "R4");
        // R2: largest exponent without carry stays normal
        issue(32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, 1'b0, "R2");
        idle(1);
        // R5: underflow, both signs
        issue(32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, "R5");
        issue(32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1, "R5");
        // R5: smallest normal exponent, no underflow
        issue(32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0, "R5");
        // R5: normalisation carry rescues from underflow
        issue(32'h00C00000, 32'h3F400000, 32'h00900000, 1'b0, 1'b0, "R5");
        // R10: non-zero operand with zero exponent field
        issue(32'h00000001, 32'h7F000000, 32'h3F800001, 1'b0, 1'b0, "R10");
        idle(3);

        // R7: back-to-back operations, mixed patterns against the reference
        for (int k = 0; k < 40; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            ra   = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            rb   = seed;
            if (k % 2 == 0) begin
                ra[30:23] = 8'd100 + 8'(ra[5:0]);
                rb[30:23] = 8'd100 + 8'(rb[5:0]);
            end
            issue_ref(ra, rb, "R3");
        end
        idle(2);

        summary();
        $finish;
    end

endmodule